// File: doc/BRIEF.md
# Halt-Gated Time Snapshot Buffer

This block keeps a byte-addressed copy of the live time-of-day vector. Software reads the copy, never the running counters. While the freeze flag is clear, each one-second tick reloads the copy from the live time. While the flag is set, the copy holds its value and the live counters outside the block keep running.

The flag sets itself on the cycle the supply enters backup power. The same clock edge captures the live time, so the copy becomes a power-down time stamp. That stamp stays readable after power returns, until software clears the flag through the control byte. Software can also set the flag by hand to freeze the copy. A build parameter chooses what happens when software clears the flag. In one build the copy reloads at once. In the other it waits for the next tick.

Top module: `rtc_snapshot_buf`

## Requirements
- R1: While `rst_n` is low at a clock edge, the freeze flag goes to 0, the snapshot goes to all zeros and the backup-edge history goes to "not in backup". A backup level that is already high when reset is released therefore counts as an entry.
- R2: At a clock edge where `tick_i` is 1 and the freeze flag is 0, the snapshot loads `live_i`.
- R3: At the first clock edge where `bkup_i` is 1 after an edge where it was 0, the freeze flag becomes 1 and the snapshot loads `live_i`. This holds whatever `tick_i` and the bus are doing on that edge.
- R4: While the freeze flag is 1, ticks do not change the snapshot. Holding `bkup_i` high does not capture again.
- R5: The read data is combinational from `rd_addr_i`. Address k, for k below `N_BYTES`, returns bits [8k+7:8k] of the snapshot. Address `CTRL_ADDR` (default 0x09) returns the freeze flag at bit `HALT_BIT` (default 7) with every other bit 0. Every other address returns 0.
- R6: A write (`wr_en_i`=1) to `CTRL_ADDR` loads the freeze flag from bit `HALT_BIT` of `wr_data_i`.
- R7: With `RELOAD_ON_CLEAR`=1, a control write that changes the flag from 1 to 0 also loads `live_i` into the snapshot on that edge. With `RELOAD_ON_CLEAR`=0, the copy stays unchanged until the next qualifying tick.
- R8: When a backup entry and a control write fall on the same edge, the backup entry wins: the flag ends at 1 and the snapshot holds the captured time.
- R9: A write to any address other than `CTRL_ADDR` changes neither the flag nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| live_i | input | 8*N_BYTES | Live time vector from the running counters |
| bkup_i | input | 1 | High while the supply runs on backup power |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 8 | Register read data |
| snap_o | output | 8*N_BYTES | Full snapshot vector |
| halt_o | output | 1 | Freeze flag |

## Verification
The bench builds two copies of the block with the default sizes: seven time bytes, 8-bit addresses and the control byte at 0x09. One copy has `RELOAD_ON_CLEAR`=1 and the other has `RELOAD_ON_CLEAR`=0. Both copies take the same stimulus, so every clearing write shows both reload policies side by side. The 8-bit address space lets random reads and writes reach the snapshot bytes, the control byte and the unmapped addresses. Random backup toggling lands entries on ticks and on control writes, and directed sequences hold backup high through reset and across many ticks.

// File: rtl/tsb_pkg.sv
// Package: shared constants and types for the snapshot buffer.
// Assumes byte-wide register lanes.
package tsb_pkg;
    localparam int LANE_W = 8;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/tsb_backup_edge.sv
// Module: detects entry into backup power as a one-cycle pulse.
// Assumes bkup_i is already synchronous to clk.
module tsb_backup_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bkup_i,
    output logic enter_o
);
    logic bkup_q;

    // Remember the previous backup level; reset means "not in backup".
    always_ff @(posedge clk) begin
        if (!rst_n) bkup_q <= 1'b0;
        else        bkup_q <= bkup_i;
    end

    assign enter_o = bkup_i & ~bkup_q;

    AST_ENTER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |=> !enter_o); // R4
endmodule

// File: rtl/tsb_halt_ctrl.sv
// Module: freeze-flag register with backup entry and software write.
// Assumes a backup entry has priority over a same-cycle write.
module tsb_halt_ctrl #(
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 9,
    parameter int HALT_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  tsb_pkg::lane_t    wr_data_i,
    output logic              halt_o,
    output logic              clear_o
);
    logic ctrl_wr;
    logic halt_q;
    logic halt_d;

    // Decode a write aimed at the control byte.
    always_comb ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

    // Next flag value: backup entry first, then software write.
    always_comb begin
        halt_d = halt_q;
        if (enter_i)      halt_d = 1'b1;
        else if (ctrl_wr) halt_d = wr_data_i[HALT_BIT];
    end

    // Hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halt_d;
    end

    assign halt_o  = halt_q;
    assign clear_o = ctrl_wr && !enter_i && halt_q && !wr_data_i[HALT_BIT];

    AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> halt_q); // R3
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR) && !enter_i)
        |=> halt_q == $past(wr_data_i[HALT_BIT])); // R6
    AST_OTHER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != ADDR_W'(CTRL_ADDR) && !enter_i)
        |=> $stable(halt_q)); // R9
    AST_RST_FLAG: assert property (@(posedge clk)
        !rst_n |=> !halt_q); // R1
endmodule

// File: rtl/tsb_snap_store.sv
// Module: byte-lane snapshot register with reload policy chosen by parameter.
// Assumes live_i is stable around the clock edge.
module tsb_snap_store #(
    parameter int N_BYTES         = 7,
    parameter bit RELOAD_ON_CLEAR = 1'b1,
    localparam int TIME_W         = N_BYTES * tsb_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              enter_i,
    input  logic              halt_i,
    input  logic              clear_i,
    input  logic [TIME_W-1:0] live_i,
    output logic [TIME_W-1:0] snap_o
);
    logic load;

    // Select the reload policy for a clearing write.
    generate
        if (RELOAD_ON_CLEAR) begin : g_eager
            always_comb load = enter_i || (tick_i && !halt_i) || clear_i;
        end else begin : g_lazy
            always_comb load = enter_i || (tick_i && !halt_i);
        end
    endgenerate

    // One register per byte lane.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
        tsb_pkg::lane_t lane_q;
        // Load the lane from the live time when a reload is due.
        always_ff @(posedge clk) begin
            if (!rst_n)    lane_q <= '0;
            else if (load) lane_q <= live_i[k*tsb_pkg::LANE_W +: tsb_pkg::LANE_W];
        end
        assign snap_o[k*tsb_pkg::LANE_W +: tsb_pkg::LANE_W] = lane_q;
    end

    AST_TICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halt_i) |=> snap_o == $past(live_i)); // R2
    AST_ENTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> snap_o == $past(live_i)); // R3
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !enter_i && !clear_i) |=> $stable(snap_o)); // R4
    AST_RST_SNAP: assert property (@(posedge clk)
        !rst_n |=> snap_o == '0); // R1
endmodule

// File: rtl/tsb_read_mux.sv
// Module: combinational register read path.
// Assumes CTRL_ADDR lies above the snapshot bytes.
module tsb_read_mux #(
    parameter int N_BYTES   = 7,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 9,
    parameter int HALT_BIT  = 7,
    localparam int TIME_W   = N_BYTES * tsb_pkg::LANE_W
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [TIME_W-1:0] snap_i,
    input  logic              halt_i,
    output tsb_pkg::lane_t    rd_data_o
);
    // Pick a snapshot byte, the control byte, or zero.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (rd_addr_i == ADDR_W'(k))
                rd_data_o = snap_i[k*tsb_pkg::LANE_W +: tsb_pkg::LANE_W];
        end
        if (rd_addr_i == ADDR_W'(CTRL_ADDR))
            rd_data_o[HALT_BIT] = halt_i;
    end

    always_comb begin
        if (rd_addr_i == ADDR_W'(CTRL_ADDR))
            AST_CTRL_RD: assert ($countones(rd_data_o) <= 1); // R5
    end
endmodule

// File: rtl/rtc_snapshot_buf.sv
// Module: top of the halt-gated time snapshot buffer.
// Assumes all inputs are synchronous to clk and tick_i is a one-cycle pulse.
module rtc_snapshot_buf #(
    parameter int N_BYTES         = 7,
    parameter int ADDR_W          = 8,
    parameter int CTRL_ADDR       = 9,
    parameter int HALT_BIT        = 7,
    parameter bit RELOAD_ON_CLEAR = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [N_BYTES*8-1:0]   live_i,
    input  logic                   bkup_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [7:0]             rd_data_o,
    output logic [N_BYTES*8-1:0]   snap_o,
    output logic                   halt_o
);
    logic enter;
    logic clear;
    logic halt;

    tsb_backup_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bkup_i  (bkup_i),
        .enter_o (enter)
    );

    tsb_halt_ctrl #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .HALT_BIT  (HALT_BIT)
    ) u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_i   (enter),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .halt_o    (halt),
        .clear_o   (clear)
    );

    tsb_snap_store #(
        .N_BYTES         (N_BYTES),
        .RELOAD_ON_CLEAR (RELOAD_ON_CLEAR)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .enter_i (enter),
        .halt_i  (halt),
        .clear_i (clear),
        .live_i  (live_i),
        .snap_o  (snap_o)
    );

    tsb_read_mux #(
        .N_BYTES   (N_BYTES),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .HALT_BIT  (HALT_BIT)
    ) u_rd (
        .rd_addr_i (rd_addr_i),
        .snap_i    (snap_o),
        .halt_i    (halt),
        .rd_data_o (rd_data_o)
    );

    assign halt_o = halt;

    AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (bkup_i && !$past(bkup_i) && wr_en_i) |=> halt_o); // R8
    AST_CLEAR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (RELOAD_ON_CLEAR && clear) |=> snap_o == $past(live_i)); // R7
endmodule

// File: tb/rtc_snapshot_buf_test.sv
`timescale 1ns/1ps
module rtc_snapshot_buf_test;
    localparam int NB = 7;
    localparam int TW = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, bkup = 1'b0, wr_en = 1'b0;
    logic [TW-1:0] live = '0;
    logic [7:0]    wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0]    rd_e, rd_l;
    logic [TW-1:0] snap_e, snap_l;
    logic          halt_e, halt_l;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // expected state
    logic          m_halt = 0, m_prev = 0;
    logic [TW-1:0] m_snap_e = '0, m_snap_l = '0;
    string         tag_s = "R1", tag_l = "R1", tag_h = "R1";

    always #2.5 clk = ~clk;

    rtc_snapshot_buf #(.RELOAD_ON_CLEAR(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .live_i(live), .bkup_i(bkup),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_e), .snap_o(snap_e), .halt_o(halt_e));

    rtc_snapshot_buf #(.RELOAD_ON_CLEAR(1'b0)) uut_lazy (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .live_i(live), .bkup_i(bkup),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_l), .snap_o(snap_l), .halt_o(halt_l));

    function automatic logic [7:0] exp_rd(logic [7:0] a, logic [TW-1:0] s, logic h);
        if (a < NB) return s[a*8 +: 8];
        if (a == 8'h09) return {h, 7'b0};
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Work out the state after the coming edge, and the requirement each change belongs to.
    task automatic predict();
        logic rise, ctrl, clr, tload;
        if (!rst_n) begin
            m_halt = 0; m_prev = 0; m_snap_e = '0; m_snap_l = '0;
            tag_s = "R1"; tag_l = "R1"; tag_h = "R1";
            return;
        end
        rise  = bkup && !m_prev;
        ctrl  = wr_en && wr_addr == 8'h09;
        clr   = ctrl && !wr_data[7] && m_halt && !rise;
        tload = tick && !m_halt;
        tag_h = (rise && wr_en) ? "R8" : rise ? "R3" : ctrl ? "R6" : wr_en ? "R9" : "R4";
        tag_s = rise ? ((wr_en) ? "R8" : "R3") : clr ? "R7" : tload ? "R2" : m_halt ? "R4" : (wr_en ? "R9" : "R2");
        tag_l = (clr && !rise && !tload) ? "R7" : tag_s;
        if (rise || tload || clr) m_snap_e = live;
        if (rise || tload)        m_snap_l = live;
        m_halt = rise ? 1'b1 : ctrl ? wr_data[7] : m_halt;
        m_prev = bkup;
    endtask

    task automatic cycle();
        predict();
        @(posedge clk); #1;
        chk(tag_h, 64'(halt_e), 64'(m_halt));
        chk(tag_h, 64'(halt_l), 64'(m_halt));
        chk(tag_s, 64'(snap_e), 64'(m_snap_e));
        chk(tag_l, 64'(snap_l), 64'(m_snap_l));
        chk("R5", 64'(rd_e), 64'(exp_rd(rd_addr, m_snap_e, m_halt)));
        chk("R5", 64'(rd_l), 64'(exp_rd(rd_addr, m_snap_l, m_halt)));
    endtask

    task automatic drive(logic t, logic b, logic w, logic [7:0] wa, logic [7:0] wd);
        tick = t; bkup = b; wr_en = w; wr_addr = wa; wr_data = wd;
        live = {$urandom, $urandom};
        rd_addr = 8'($urandom_range(0, 11));
    endtask

    initial begin
        #(250000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with backup held high
        drive(1, 1, 1, 8'h09, 8'h80);
        cycle(); cycle();
        rst_n = 1'b1;
        // R3: first edge after reset sees a backup entry
        drive(1, 1, 0, 0, 0); cycle();
        // R4: stay in backup across ticks
        for (int i = 0; i < 5; i++) begin drive(1, 1, 0, 0, 0); cycle(); end
        // R9: writes to snapshot and unmapped addresses
        drive(0, 1, 1, 8'h02, 8'h00); cycle();
        drive(0, 1, 1, 8'h20, 8'h00); cycle();
        // R7: clear flag, compare eager vs lazy, then tick
        drive(0, 0, 1, 8'h09, 8'h00); cycle();
        drive(0, 0, 0, 0, 0); cycle();
        drive(1, 0, 0, 0, 0); cycle();
        // R6: manual freeze then tick
        drive(0, 0, 1, 8'h09, 8'h80); cycle();
        drive(1, 0, 0, 0, 0); cycle();
        // R8: backup entry beats a clearing write
        drive(1, 1, 1, 8'h09, 8'h00); cycle();
        drive(0, 0, 0, 0, 0); cycle();
        // mixed random
        for (int i = 0; i < 4000; i++) begin
            logic b;
            b = ($urandom_range(0, 15) == 0) ? ~bkup : bkup;
            drive($urandom_range(0, 3) == 0, b, $urandom_range(0, 3) == 0,
                  ($urandom_range(0, 1) == 0) ? 8'h09 : 8'($urandom_range(0, 255)),
                  8'($urandom));
            cycle();
        end
        // R1: reset in mid-run
        rst_n = 1'b0; drive(0, 0, 0, 0, 0); cycle();
        rst_n = 1'b1; drive(1, 0, 0, 0, 0); cycle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule